// File: doc/BRIEF.md
# Trigger-Configurable Limit Timer

This block is an up-counter that runs from 00h toward a programmable limit and is steered by one external signal. A five-bit mode word decides whether that signal is ignored, acts as a run gate, resets the count on an edge or a level, or starts a single timed run. The run can then end with the enable cleared (one-shot) or with the enable kept so that a later trigger fires the timer again (monostable). Software raises the enable with a set strobe and drops it with a clear strobe. The hardware clears the enable by itself when a one-shot run completes.

The external signal passes through a synchronizer before it is used. A debug input freezes the signal's effect, so a halted system does not see spurious triggers. The count, a one-cycle wrap pulse and the live enable are driven out for the surrounding logic.

Top module: `trig_limit_timer`

## Requirements
- R1: While `rst_n` is low, `count_o` is 00h, `wrap_o` is 0 and `on_o` is 0.
- R2: Mode bits [4:3] pick the class: 00 periodic, 01 one-shot, 10 monostable, 11 reserved. In class 11, and in monostable sub-modes 000, 100 and 101, the count does not move.
- R3: In periodic sub-mode 000 with the enable set, the count steps by one each clock from 00h up to `limit_i`. On the next clock it returns to 00h, and `wrap_o` is high for exactly that one cycle.
- R4: `on_set_i` sets the enable and `on_clr_i` clears it, and the clear wins when both are high. While the enable is 0 the count holds its value in every mode, and triggers have no effect.
- R5: Periodic sub-mode 001 counts only while the synchronized signal is high, and sub-mode 010 only while it is low. Otherwise the count holds.
- R6: Periodic sub-modes 011, 100 and 101 keep counting, and return the count to 00h on any edge, a rising edge or a falling edge respectively. A change on `ext_i` reaches the count on the third rising clock edge after it is applied.
- R7: Periodic sub-mode 110 holds the count at 00h while the signal is low, and sub-mode 111 does so while it is high.
- R8: In any one-shot mode, once the count equals `limit_i`, the next clock sets the count to 00h, pulses `wrap_o` and clears `on_o`. Sub-mode 000 starts as soon as the enable is set.
- R9: One-shot sub-modes 001/010/011 start on a rising, falling or any edge seen while the enable is 1. A level or edge that came before the enable was set does not start a run.
- R10: One-shot sub-modes 100 and 101 start on a rising or falling edge, and the same edge restarts the count from 00h during a run. Sub-mode 110 starts on a rising edge and is held at 00h while the signal is low. Sub-mode 111 starts on a falling edge and is held at 00h while the signal is high.
- R11: Monostable sub-modes 001/010/011 start on a rising, falling or any edge. On completion the count returns to 00h with one `wrap_o` pulse, and the enable stays 1, so a later edge fires the timer again.
- R12: Mode 10110 runs while the signal is high and is held at 00h while it is low. Mode 10111 is the inverse. Both clear the enable on completion.
- R13: While `dbg_i` is high, changes on `ext_i` produce no edges, and the level last seen stays in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| on_set_i | input | 1 | Strobe that sets the enable |
| on_clr_i | input | 1 | Strobe that clears the enable; wins over set |
| limit_i | input | CW (8) | Count value at which a period completes |
| mode_i | input | 5 | Class in [4:3], variant in [2:0] |
| ext_i | input | 1 | External gate, trigger or reset signal, asynchronous |
| dbg_i | input | 1 | Debug halt; freezes the effect of `ext_i` |
| count_o | output | CW (8) | Current count |
| wrap_o | output | 1 | One-cycle pulse when a period or run completes |
| on_o | output | 1 | Enable as updated by software and hardware |

## Verification
The bench applies an edge to `ext_i` before the enable is set. A design that latched that edge would start a one-shot run that should never happen. Edge resets are checked on the exact cycle after synchronization. A timer that reacted to the wrong polarity, or had one synchronizer flop too few or too many, would show a nonzero count where 00h is due. On completion the bench tells one-shot from monostable by the value of `on_o`. A monostable that cleared its enable would miss its second trigger, and a one-shot that kept its enable would restart. Debug is exercised by toggling `ext_i` while it is high. A leaking trigger would show up as a wrap pulse. The bench also confirms that the reserved modes and the clear-over-set rule leave the count and the enable untouched.

// File: rtl/tlt_pkg.sv
package tlt_pkg;

  typedef enum logic [1:0] {
    CLS_PERIODIC = 2'b00,
    CLS_ONESHOT  = 2'b01,
    CLS_MONO     = 2'b10,
    CLS_RSVD     = 2'b11
  } tlt_cls_e;

  // Decoded per-cycle control derived from mode and trigger state
  typedef struct packed {
    logic hold;      // no operation this cycle
    logic periodic;  // free-running class
    logic gate;      // periodic: counting permitted
    logic edge_rst;  // edge driven restart from 00h
    logic lvl_rst;   // level driven hold at 00h
    logic start;     // run start condition (one-shot / monostable)
    logic clr_on;    // completion clears the enable
  } tlt_ctl_t;

endpackage

// File: rtl/tlt_trig_sync.sv
module tlt_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic dbg_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              smp;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= ext_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign smp = chain_q[LAST];

  // previous accepted sample; frozen while debug is active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= 1'b0;
    else if (!dbg_i) prev_q <= smp;
  end

  always_comb begin
    lvl_o  = dbg_i ? prev_q : smp;
    rise_o = !dbg_i &&  smp && !prev_q;
    fall_o = !dbg_i && !smp &&  prev_q;
  end

endmodule

// File: rtl/tlt_mode_dec.sv
module tlt_mode_dec
  import tlt_pkg::*;
(
  input  logic [4:0] mode_i,
  input  logic       lvl_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output tlt_ctl_t   ctl_o
);

  tlt_cls_e   cls;
  logic [2:0] sub;
  logic       any_edge;

  assign cls      = tlt_cls_e'(mode_i[4:3]);
  assign sub      = mode_i[2:0];
  assign any_edge = rise_i | fall_i;

  always_comb begin
    ctl_o = '0;
    unique case (cls)
      CLS_PERIODIC: begin
        ctl_o.periodic = 1'b1;
        ctl_o.gate     = 1'b1;
        unique case (sub)
          3'b001:  ctl_o.gate     = lvl_i;
          3'b010:  ctl_o.gate     = !lvl_i;
          3'b011:  ctl_o.edge_rst = any_edge;
          3'b100:  ctl_o.edge_rst = rise_i;
          3'b101:  ctl_o.edge_rst = fall_i;
          3'b110:  ctl_o.lvl_rst  = !lvl_i;
          3'b111:  ctl_o.lvl_rst  = lvl_i;
          default: ctl_o.gate     = 1'b1;
        endcase
      end
      CLS_ONESHOT: begin
        ctl_o.clr_on = 1'b1;
        unique case (sub)
          3'b000: ctl_o.start = 1'b1;
          3'b001: ctl_o.start = rise_i;
          3'b010: ctl_o.start = fall_i;
          3'b011: ctl_o.start = any_edge;
          3'b100: begin ctl_o.start = rise_i; ctl_o.edge_rst = rise_i; end
          3'b101: begin ctl_o.start = fall_i; ctl_o.edge_rst = fall_i; end
          3'b110: begin ctl_o.start = rise_i; ctl_o.lvl_rst  = !lvl_i; end
          default: begin ctl_o.start = fall_i; ctl_o.lvl_rst = lvl_i; end
        endcase
      end
      CLS_MONO: begin
        unique case (sub)
          3'b001: ctl_o.start = rise_i;
          3'b010: ctl_o.start = fall_i;
          3'b011: ctl_o.start = any_edge;
          3'b110: begin
            ctl_o.start   = lvl_i;
            ctl_o.lvl_rst = !lvl_i;
            ctl_o.clr_on  = 1'b1;
          end
          3'b111: begin
            ctl_o.start   = !lvl_i;
            ctl_o.lvl_rst = lvl_i;
            ctl_o.clr_on  = 1'b1;
          end
          default: ctl_o.hold = 1'b1;
        endcase
      end
      default: ctl_o.hold = 1'b1;
    endcase
  end

endmodule

// File: rtl/tlt_count_core.sv
module tlt_count_core
  import tlt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_set_i,
  input  logic          on_clr_i,
  input  logic [CW-1:0] limit_i,
  input  tlt_ctl_t      ctl_i,
  output logic [CW-1:0] count_o,
  output logic          wrap_o,
  output logic          on_o
);

  localparam logic [CW-1:0] CNT_ZERO = '0;
  localparam logic [CW-1:0] CNT_ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          on_q, on_d;
  logic          wrap_q, wrap_d;
  logic          cnt_en, act_en;
  logic          at_limit;
  logic          done;

  assign at_limit = (cnt_q == limit_i);

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    wrap_d = 1'b0;
    done   = 1'b0;
    if (!on_q) begin
      act_d = 1'b0;
    end else if (ctl_i.hold) begin
      act_d = act_q;
    end else if (ctl_i.periodic) begin
      if (ctl_i.lvl_rst || ctl_i.edge_rst) begin
        cnt_d = CNT_ZERO;
      end else if (ctl_i.gate) begin
        if (at_limit) begin
          cnt_d  = CNT_ZERO;
          wrap_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
    end else begin
      if (ctl_i.lvl_rst) begin
        cnt_d = CNT_ZERO;
        act_d = 1'b0;
      end else if (ctl_i.edge_rst) begin
        cnt_d = CNT_ZERO;
        act_d = 1'b1;
      end else if (act_q) begin
        if (at_limit) begin
          cnt_d  = CNT_ZERO;
          act_d  = 1'b0;
          wrap_d = 1'b1;
          done   = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end else if (ctl_i.start) begin
        act_d = 1'b1;
      end
    end

    if (on_clr_i)                   on_d = 1'b0;
    else if (done && ctl_i.clr_on)  on_d = 1'b0;
    else if (on_set_i)              on_d = 1'b1;
    else                            on_d = on_q;
  end

  assign cnt_en = (cnt_d != cnt_q);
  assign act_en = (act_d != act_q);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_ZERO;
      act_q  <= 1'b0;
      on_q   <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (act_en) act_q <= act_d;
      on_q   <= on_d;
      wrap_q <= wrap_d;
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = wrap_q;
  assign on_o    = on_q;

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (cnt_q == CNT_ZERO)); // R3

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |=> $stable(cnt_q)); // R4

  AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.hold |=> $stable(cnt_q)); // R2

  AST_ONESHOT_DROPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && act_q && at_limit && !ctl_i.hold && !ctl_i.periodic && ctl_i.clr_on
     && !ctl_i.lvl_rst && !ctl_i.edge_rst)
    |=> (!on_q && cnt_q == CNT_ZERO && wrap_q)); // R8

  AST_MONO_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && act_q && at_limit && !ctl_i.hold && !ctl_i.periodic && !ctl_i.clr_on
     && !ctl_i.lvl_rst && !ctl_i.edge_rst && !on_clr_i)
    |=> (on_q && cnt_q == CNT_ZERO)); // R11

endmodule

// File: rtl/trig_limit_timer.sv
module trig_limit_timer
  import tlt_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_set_i,
  input  logic          on_clr_i,
  input  logic [CW-1:0] limit_i,
  input  logic [4:0]    mode_i,
  input  logic          ext_i,
  input  logic          dbg_i,
  output logic [CW-1:0] count_o,
  output logic          wrap_o,
  output logic          on_o
);

  logic     trig_lvl, trig_rise, trig_fall;
  tlt_ctl_t ctl;

  tlt_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_i  (ext_i),
    .dbg_i  (dbg_i),
    .lvl_o  (trig_lvl),
    .rise_o (trig_rise),
    .fall_o (trig_fall)
  );

  tlt_mode_dec u_dec (
    .mode_i (mode_i),
    .lvl_i  (trig_lvl),
    .rise_i (trig_rise),
    .fall_i (trig_fall),
    .ctl_o  (ctl)
  );

  tlt_count_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .on_set_i (on_set_i),
    .on_clr_i (on_clr_i),
    .limit_i  (limit_i),
    .ctl_i    (ctl),
    .count_o  (count_o),
    .wrap_o   (wrap_o),
    .on_o     (on_o)
  );

  AST_DBG_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_i |-> !(trig_rise || trig_fall)); // R13

endmodule

// File: tb/trig_limit_timer_bench.sv
`timescale 1ns/1ps
module trig_limit_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       on_set, on_clr, ext, dbg;
  logic [7:0] limit;
  logic [4:0] mode;
  logic [7:0] count;
  logic       wrap, on;

  int checks = 0;
  int errors = 0;
  int wraps  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trig_limit_timer u_trig_limit_timer (
    .clk(clk), .rst_n(rst_n), .on_set_i(on_set), .on_clr_i(on_clr),
    .limit_i(limit), .mode_i(mode), .ext_i(ext), .dbg_i(dbg),
    .count_o(count), .wrap_o(wrap), .on_o(on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wrap) wraps++;
    end
  endtask

  task automatic do_reset(input logic [4:0] m, input logic [7:0] lim);
    @(negedge clk);
    rst_n = 1'b0; on_set = 0; on_clr = 0; ext = 0; dbg = 0;
    mode = m; limit = lim;
    step(2);
    rst_n = 1'b1;
    step(1);
    wraps = 0;
  endtask

  task automatic pulse_on();
    on_set = 1'b1; step(1); on_set = 1'b0;
  endtask

  task automatic pulse_off();
    on_clr = 1'b1; step(1); on_clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; on_set = 0; on_clr = 0; ext = 0; dbg = 0; mode = 0; limit = 8'd4;
    step(2);
    chk(count == 0 && !wrap && !on, "R1 reset state", {count, 7'd0, wrap, 7'd0, on}, 0);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_periodic();
    int bad = 0;
    do_reset(5'b00000, 8'd4);
    pulse_on();
    chk(on == 1, "R4 set strobe", on, 1);
    for (int i = 1; i <= 20; i++) begin
      int e = i % 5;
      step(1);
      if (count != e || wrap != (e == 0)) bad++;
    end
    chk(bad == 0, "R3 count/wrap sequence", bad, 0);
    step(2);
    pulse_off();
    step(5);
    chk(count == 3 && on == 0, "R4 off holds count", count, 3);
    on_set = 1; on_clr = 1; step(1); on_set = 0; on_clr = 0;
    step(3);
    chk(on == 0 && count == 3, "R4 clear beats set", on, 0);
  endtask

  task automatic t_gate();
    do_reset(5'b00001, 8'd50);
    pulse_on();
    step(6);
    chk(count == 0, "R5 gate high blocked", count, 0);
    ext = 1; step(10);
    chk(count == 8, "R5 gate high counts", count, 8);
    mode = 5'b00010; step(4);
    chk(count == 8, "R5 gate low blocked", count, 8);
    ext = 0; step(5);
    chk(count == 11, "R5 gate low counts", count, 11);
  endtask

  task automatic t_edge_rst();
    do_reset(5'b00100, 8'd200);
    pulse_on();
    step(20);
    chk(count == 20, "R3 free count", count, 20);
    ext = 1; step(3);
    chk(count == 0, "R6 rising edge reset timing", count, 0);
    ext = 0; step(3);
    chk(count == 3, "R6 falling ignored in rise mode", count, 3);
    mode = 5'b00101; ext = 1; step(3);
    chk(count == 6, "R6 rising ignored in fall mode", count, 6);
    ext = 0; step(3);
    chk(count == 0, "R6 falling edge reset", count, 0);
    mode = 5'b00011; step(5);
    ext = 1; step(3);
    chk(count == 0, "R6 any edge reset", count, 0);
  endtask

  task automatic t_lvl_rst();
    do_reset(5'b00110, 8'd100);
    pulse_on();
    step(8);
    chk(count == 0, "R7 low level holds zero", count, 0);
    ext = 1; step(6);
    chk(count == 4, "R7 released counts", count, 4);
    mode = 5'b00111; step(2);
    chk(count == 0, "R7 high level holds zero", count, 0);
  endtask

  task automatic t_oneshot();
    int mx = 0;
    do_reset(5'b01000, 8'd5);
    pulse_on();
    for (int i = 0; i < 15; i++) begin
      step(1);
      if (count > mx) mx = count;
    end
    chk(wraps == 1, "R8 single wrap", wraps, 1);
    chk(mx == 5, "R8 peak count", mx, 5);
    chk(on == 0 && count == 0, "R8 enable cleared at end", on, 0);
  endtask

  task automatic t_edge_start();
    do_reset(5'b01001, 8'd3);
    ext = 1; step(6);
    pulse_on();
    step(8);
    chk(count == 0 && on == 1 && wraps == 0, "R9 early edge ignored", count, 0);
    ext = 0; step(6);
    ext = 1; step(15);
    chk(wraps == 1 && on == 0, "R9 new edge starts run", wraps, 1);
  endtask

  task automatic t_oneshot_rst();
    do_reset(5'b01100, 8'd30);
    pulse_on();
    ext = 1; step(13);
    chk(count == 10, "R10 edge start", count, 10);
    ext = 0; step(6);
    ext = 1; step(3);
    chk(count == 0 && on == 1, "R10 edge restart", count, 0);
    step(40);
    chk(wraps == 1 && on == 0, "R10 run completes", wraps, 1);
    do_reset(5'b01110, 8'd30);
    pulse_on();
    ext = 1; step(10);
    chk(count == 7, "R10 rise start low reset mode", count, 7);
    ext = 0; step(8);
    chk(count == 0 && on == 1, "R10 low level reset", count, 0);
  endtask

  task automatic t_mono();
    do_reset(5'b10001, 8'd3);
    pulse_on();
    ext = 1; step(3); ext = 0; step(12);
    chk(wraps == 1 && on == 1, "R11 enable kept after run", on, 1);
    ext = 1; step(3); ext = 0; step(12);
    chk(wraps == 2 && count == 0, "R11 retrigger", wraps, 2);
  endtask

  task automatic t_level();
    do_reset(5'b10110, 8'd4);
    pulse_on();
    ext = 1; step(15);
    chk(wraps == 1 && on == 0 && count == 0, "R12 high level run", wraps, 1);
    mode = 5'b10111;
    pulse_on();
    step(6);
    chk(count == 0 && on == 1, "R12 inverse held by high", count, 0);
    ext = 0; step(15);
    chk(wraps == 2 && on == 0, "R12 inverse low level run", wraps, 2);
  endtask

  task automatic t_dbg();
    do_reset(5'b10001, 8'd3);
    pulse_on();
    dbg = 1; ext = 1; step(4); ext = 0; step(6); dbg = 0; step(4);
    chk(wraps == 0 && count == 0 && on == 1, "R13 trigger ignored in debug", wraps, 0);
    ext = 1; step(12);
    chk(wraps == 1, "R13 trigger accepted after debug", wraps, 1);
  endtask

  task automatic t_rsvd();
    do_reset(5'b00000, 8'd200);
    pulse_on();
    step(10);
    mode = 5'b11001;
    ext = 1; step(4); ext = 0; step(4);
    chk(count == 10, "R2 reserved class holds", count, 10);
    mode = 5'b10100; ext = 1; step(5);
    chk(count == 10, "R2 reserved monostable holds", count, 10);
  endtask

  initial begin
    rst_n = 0; on_set = 0; on_clr = 0; ext = 0; dbg = 0; mode = 0; limit = 0;
    t_reset();
    t_periodic();
    t_gate();
    t_edge_rst();
    t_lvl_rst();
    t_oneshot();
    t_edge_start();
    t_oneshot_rst();
    t_mono();
    t_level();
    t_dbg();
    t_rsvd();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule